// File: doc/BRIEF.md
# Paged Memory Window Controller

This block lets a CPU with a 16-bit address space reach up to 64 KiB of extra memory through a 256-byte window. An 8-bit page register sits at a fixed I/O address. A second 256-byte I/O page acts as the window. When the CPU touches an address in the window page, the block forms a 16-bit extended address. The page register supplies the upper byte and the low CPU address byte supplies the lower byte. The block then issues a one-cycle read or write strobe to the extended memory.

The raw decode lines that mark the two I/O pages are assumed to glitch, so the block never uses them directly. A select counts only while the slow bus clock phase is high, and only once it has been seen on several consecutive samples of the fast system clock. Each high phase of the bus clock yields at most one access, which prevents a held bus cycle from touching a device twice. On CPU reads of the window or the page register, the block drives the read data together with an output-enable, so the shared data bus stays high-impedance for every other address. A status output reports whether the current page lies in the reserved lower half of the page range.

Top module: `pw_window_ctrl`

## Requirements
- R1: While reset is high and after it is released, the page register holds 0x00, `xm_rd`, `xm_wr` and `cpu_doe` are low, `cpu_dout` is 0x00 and `pg_reserved` is high.
- R2: A qualified read at CPU address 0xFDxx pulses `xm_rd` for exactly one clock, on the clock after the qualifying sample. `xm_addr` carries {page, xx}, and the memory data appears on `cpu_dout` with `cpu_doe` high.
- R3: A qualified write at 0xFDxx pulses `xm_wr` for one clock with `xm_addr` = {page, xx} and `xm_wdata` equal to the CPU write data.
- R4: A qualified write at 0xFCFF loads the page register with the CPU data. A qualified read at 0xFCFF drives the page value on `cpu_dout` with `cpu_doe` high, and no memory strobe is issued.
- R5: Raw selects have no effect while `bus_phase` is low.
- R6: A raw select counts only when it is high, with `bus_phase` high, on FILT_DEPTH+1 consecutive system clock samples (3 by default). A shorter pulse issues nothing.
- R7: At most one access (strobe or register access) happens per high phase of `bus_phase`, however long the phase lasts.
- R8: A qualified select whose address is neither 0xFDxx (for the window select) nor 0xFCFF (for the page select) gives no strobe, no output-enable and no change to the page register.
- R9: `pg_reserved` is high exactly when the page register is below 0x80.
- R10: `cpu_doe` falls on the clock after `bus_phase` goes low. A page write is used by the next window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_phase | input | 1 | Level of the slow bus clock, synchronous to clk |
| win_sel_raw | input | 1 | Unfiltered decode of the window I/O page |
| preg_sel_raw | input | 1 | Unfiltered decode of the page-register I/O page |
| cpu_addr | input | 16 | CPU address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_dout | output | 8 | Read data toward the CPU, zero when not enabled |
| cpu_doe | output | 1 | Output-enable for the CPU data bus |
| xm_addr | output | 16 | Extended memory address |
| xm_rd | output | 1 | Extended memory read strobe |
| xm_wr | output | 1 | Extended memory write strobe |
| xm_wdata | output | 8 | Extended memory write data |
| xm_rdata | input | 8 | Extended memory read data, combinational from xm_addr |
| pg_reserved | output | 1 | Current page lies in the reserved range 0x00 to 0x7F |

## Verification
The assertions assume that `bus_phase`, the raw selects and the CPU bus inputs are synchronous to `clk`. They also assume that the address, direction and write data stay steady for the whole high phase of the bus clock, and that the two raw selects are not both asserted for one CPU cycle. The stimulus changes inputs only just after a rising clock edge. It holds each bus cycle's address and data for the full phase and raises at most one raw select per cycle. Glitches are modelled only as select pulses shorter than the filter window, never as address changes inside a phase.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int CPU_AW = 16;
    localparam int DW     = 8;
    localparam int PG_W   = 8;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_WIN  = 2'd1,
        ACC_PREG = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e       kind;
        logic            rnw;
        logic [7:0]      offs;
        logic [DW-1:0]   wdata;
    } acc_req_t;

    function automatic logic page_is_reserved(input logic [PG_W-1:0] pg);
        return ~pg[PG_W-1];
    endfunction

    function automatic logic [CPU_AW-1:0] form_ext_addr(input logic [PG_W-1:0] pg,
                                                       input logic [7:0] offs);
        return {pg, offs};
    endfunction

endpackage

// File: rtl/pw_sel_filter.sv
module pw_sel_filter #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_phase,
    input  logic sel_raw,
    output logic sel_qual
);
    logic             hit;
    logic [DEPTH-1:0] hist;

    assign hit      = sel_raw & bus_phase;
    assign sel_qual = hit & (&hist);

    always_ff @(posedge clk) begin
        if (rst || !hit) begin
            hist <= '0;
        end else begin
            hist <= (hist << 1) | {{(DEPTH-1){1'b0}}, 1'b1};
        end
    end

    // R6: a qualified select needs the previous sample to have been a hit too
    a_r6_qual_needs_history: assert property (@(posedge clk) disable iff (rst)
        sel_qual |-> $past(hit));

endmodule

// File: rtl/pw_access_ctrl.sv
module pw_access_ctrl
    import pw_pkg::*;
#(
    parameter logic [7:0]        WIN_PAGE  = 8'hFD,
    parameter logic [CPU_AW-1:0] PREG_ADDR = 16'hFCFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_phase,
    input  logic              win_qual,
    input  logic              preg_qual,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rnw,
    input  logic [DW-1:0]     cpu_wdata,
    output acc_req_t          req
);
    logic done;
    logic consumed;

    assign consumed = !done && (win_qual || preg_qual);

    always_comb begin
        req       = '0;
        req.kind  = ACC_NONE;
        req.rnw   = cpu_rnw;
        req.offs  = cpu_addr[7:0];
        req.wdata = cpu_wdata;
        if (!done) begin
            if (win_qual && (cpu_addr[CPU_AW-1:8] == WIN_PAGE)) begin
                req.kind = ACC_WIN;
            end else if (preg_qual && (cpu_addr == PREG_ADDR)) begin
                req.kind = ACC_PREG;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !bus_phase) begin
            done <= 1'b0;
        end else if (consumed) begin
            done <= 1'b1;
        end
    end

    // R7: an issued access is never followed by another in the next cycle
    a_r7_single_access: assert property (@(posedge clk) disable iff (rst)
        (req.kind != ACC_NONE) |=> (req.kind == ACC_NONE));

    // R5: an access is only issued while the bus phase is high
    a_r5_access_in_phase: assert property (@(posedge clk) disable iff (rst)
        (req.kind != ACC_NONE) |-> bus_phase);

endmodule

// File: rtl/pw_page_reg.sv
module pw_page_reg
    import pw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    output logic [PG_W-1:0] page,
    output logic            reserved
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
        end else if (wr_en) begin
            page <= wdata[PG_W-1:0];
        end
    end

    assign reserved = page_is_reserved(page);

    // R4: the page only moves on a register write
    a_r4_page_changes_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(page) |-> $past(wr_en));

endmodule

// File: rtl/pw_window_ctrl.sv
module pw_window_ctrl
    import pw_pkg::*;
#(
    parameter int                FILT_DEPTH = 2,
    parameter logic [7:0]        WIN_PAGE   = 8'hFD,
    parameter logic [CPU_AW-1:0] PREG_ADDR  = 16'hFCFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_phase,
    input  logic              win_sel_raw,
    input  logic              preg_sel_raw,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rnw,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_dout,
    output logic              cpu_doe,
    output logic [CPU_AW-1:0] xm_addr,
    output logic              xm_rd,
    output logic              xm_wr,
    output logic [DW-1:0]     xm_wdata,
    input  logic [DW-1:0]     xm_rdata,
    output logic              pg_reserved
);
    localparam int NSEL = 2;

    logic [NSEL-1:0] raw_vec;
    logic [NSEL-1:0] qual_vec;
    acc_req_t        req;
    logic [PG_W-1:0] page;
    logic            page_wr;
    logic            src_win;
    logic [DW-1:0]   pg_cap;

    assign raw_vec = {preg_sel_raw, win_sel_raw};

    for (genvar g = 0; g < NSEL; g++) begin : g_filt
        pw_sel_filter #(.DEPTH(FILT_DEPTH)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .bus_phase(bus_phase),
            .sel_raw  (raw_vec[g]),
            .sel_qual (qual_vec[g])
        );
    end

    pw_access_ctrl #(.WIN_PAGE(WIN_PAGE), .PREG_ADDR(PREG_ADDR)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .bus_phase(bus_phase),
        .win_qual (qual_vec[0]),
        .preg_qual(qual_vec[1]),
        .cpu_addr (cpu_addr),
        .cpu_rnw  (cpu_rnw),
        .cpu_wdata(cpu_wdata),
        .req      (req)
    );

    assign page_wr = (req.kind == ACC_PREG) && !req.rnw;

    pw_page_reg u_page (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (page_wr),
        .wdata   (req.wdata),
        .page    (page),
        .reserved(pg_reserved)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xm_addr  <= '0;
            xm_rd    <= 1'b0;
            xm_wr    <= 1'b0;
            xm_wdata <= '0;
            cpu_doe  <= 1'b0;
            src_win  <= 1'b0;
            pg_cap   <= '0;
        end else begin
            xm_rd <= 1'b0;
            xm_wr <= 1'b0;
            if (!bus_phase) begin
                cpu_doe <= 1'b0;
            end
            case (req.kind)
                ACC_WIN: begin
                    xm_addr <= form_ext_addr(page, req.offs);
                    if (req.rnw) begin
                        xm_rd   <= 1'b1;
                        cpu_doe <= 1'b1;
                        src_win <= 1'b1;
                    end else begin
                        xm_wr    <= 1'b1;
                        xm_wdata <= req.wdata;
                    end
                end
                ACC_PREG: begin
                    if (req.rnw) begin
                        cpu_doe <= 1'b1;
                        src_win <= 1'b0;
                        pg_cap  <= page;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cpu_dout = !cpu_doe ? '0 : (src_win ? xm_rdata : pg_cap);

    // R2/R3: read and write strobes are never raised together
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(xm_rd && xm_wr));

    // R5: a strobe follows a sample taken while the bus phase was high
    a_r5_strobe_after_phase: assert property (@(posedge clk) disable iff (rst)
        (xm_rd || xm_wr) |-> $past(bus_phase));

    // R10: the output-enable is released once the bus phase has ended
    a_r10_doe_drops: assert property (@(posedge clk) disable iff (rst)
        !bus_phase |=> !cpu_doe);

    // R2: a read strobe lasts one clock
    a_r2_rd_one_cycle: assert property (@(posedge clk) disable iff (rst)
        xm_rd |=> !xm_rd);

endmodule

// File: tb/test_pw_window_ctrl.sv
module test_pw_window_ctrl;

    localparam int F = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_phase = 1'b0;
    logic        win_sel_raw = 1'b0;
    logic        preg_sel_raw = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_dout;
    logic        cpu_doe;
    logic [15:0] xm_addr;
    logic        xm_rd;
    logic        xm_wr;
    logic [7:0]  xm_wdata;
    logic [7:0]  xm_rdata;
    logic        pg_reserved;

    always #2 clk = ~clk;

    pw_window_ctrl #(.FILT_DEPTH(F)) i_pw_window_ctrl (
        .clk(clk), .rst(rst), .bus_phase(bus_phase),
        .win_sel_raw(win_sel_raw), .preg_sel_raw(preg_sel_raw),
        .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw), .cpu_wdata(cpu_wdata),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
        .xm_addr(xm_addr), .xm_rd(xm_rd), .xm_wr(xm_wr),
        .xm_wdata(xm_wdata), .xm_rdata(xm_rdata), .pg_reserved(pg_reserved)
    );

    // behavioural extended memory
    logic [7:0] mem [int];
    int mem_ver = 0;

    function automatic logic [7:0] mem_rd(input logic [15:0] a, input int ver);
        if (ver < 0) return 8'h00;
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign xm_rdata = mem_rd(xm_addr, mem_ver);

    always @(posedge clk) begin
        if (!rst && xm_wr) begin
            mem[int'(xm_addr)] = xm_wdata;
            mem_ver++;
        end
    end

    // reference model
    int          cw = 0, cp = 0;
    bit          m_done = 0;
    logic [7:0]  m_page = 8'h00;
    logic [15:0] e_addr = '0;
    logic        e_rd = 0, e_wr = 0, e_doe = 0, e_src = 0;
    logic [7:0]  e_wdata = '0, e_cap = '0;

    always @(posedge clk) begin
        if (rst) begin
            cw = 0; cp = 0; m_done = 0; m_page = 8'h00;
            e_addr = '0; e_rd = 0; e_wr = 0; e_doe = 0; e_src = 0;
            e_wdata = '0; e_cap = '0;
        end else begin
            bit hw, hp, qw, qp;
            hw = win_sel_raw && bus_phase;
            hp = preg_sel_raw && bus_phase;
            qw = hw && (cw >= F);
            qp = hp && (cp >= F);
            e_rd = 0; e_wr = 0;
            if (!bus_phase) e_doe = 0;
            if (!m_done) begin
                if (qw && cpu_addr[15:8] == 8'hFD) begin
                    e_addr = {m_page, cpu_addr[7:0]};
                    if (cpu_rnw) begin e_rd = 1; e_doe = 1; e_src = 1; end
                    else begin e_wr = 1; e_wdata = cpu_wdata; end
                end else if (qp && cpu_addr == 16'hFCFF) begin
                    if (cpu_rnw) begin e_doe = 1; e_src = 0; e_cap = m_page; end
                    else m_page = cpu_wdata;
                end
            end
            if (!bus_phase) m_done = 0;
            else if (qw || qp) m_done = 1;
            cw = hw ? ((cw < F) ? cw + 1 : cw) : 0;
            cp = hp ? ((cp < F) ? cp + 1 : cp) : 0;
        end
    end

    int vectors = 0;
    int fails = 0;
    int strobes = 0;
    int doe_rises = 0;
    logic [15:0] last_addr = '0;
    logic [7:0]  last_dout = '0;
    logic        prev_doe = 0;

    task automatic cmp(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] e_dout;
        e_dout = !e_doe ? 8'h00 : (e_src ? mem_rd(e_addr, mem_ver) : e_cap);
        cmp("R2", "xm_rd", xm_rd, e_rd);
        cmp("R3", "xm_wr", xm_wr, e_wr);
        cmp("R2", "xm_addr", xm_addr, e_addr);
        cmp("R3", "xm_wdata", xm_wdata, e_wdata);
        cmp("R4", "cpu_doe", cpu_doe, e_doe);
        cmp("R4", "cpu_dout", cpu_dout, e_dout);
        cmp("R9", "pg_reserved", pg_reserved, (m_page < 8'h80) ? 1 : 0);
        if (!rst && (xm_rd || xm_wr)) begin strobes++; last_addr = xm_addr; end
        if (!rst && cpu_doe && !prev_doe) begin doe_rises++; last_dout = cpu_dout; end
        prev_doe = cpu_doe;
    end

    task automatic bus_op(input logic [15:0] a, input logic rnw, input logic [7:0] d,
                          input logic w, input logic p, input int hi, input int raw_len,
                          input int lo);
        @(posedge clk); #1;
        cpu_addr = a; cpu_rnw = rnw; cpu_wdata = d;
        win_sel_raw = w; preg_sel_raw = p; bus_phase = 1'b1;
        repeat (raw_len) @(posedge clk);
        #1; win_sel_raw = 1'b0; preg_sel_raw = 1'b0;
        repeat (hi - raw_len) @(posedge clk);
        #1; bus_phase = 1'b0;
        repeat (lo) @(posedge clk);
    endtask

    task automatic win_wr(input logic [7:0] o, input logic [7:0] d);
        bus_op({8'hFD, o}, 1'b0, d, 1'b1, 1'b0, 8, 8, 8);
    endtask
    task automatic win_rd(input logic [7:0] o);
        bus_op({8'hFD, o}, 1'b1, 8'h00, 1'b1, 1'b0, 8, 8, 8);
    endtask
    task automatic pg_wr(input logic [7:0] d);
        bus_op(16'hFCFF, 1'b0, d, 1'b0, 1'b1, 8, 8, 8);
    endtask
    task automatic pg_rd();
        bus_op(16'hFCFF, 1'b1, 8'h00, 1'b0, 1'b1, 8, 8, 8);
    endtask

    bit finished = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int s0, d0;
        repeat (4) @(posedge clk);
        #1; rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        cmp("R1", "xm_rd", xm_rd, 0);
        cmp("R1", "cpu_doe", cpu_doe, 0);
        cmp("R1", "cpu_dout", cpu_dout, 0);
        cmp("R1", "pg_reserved", pg_reserved, 1);

        pg_wr(8'h12);
        pg_rd();
        cmp("R4", "page readback", last_dout, 8'h12);
        cmp("R9", "reserved low page", pg_reserved, 1);

        s0 = strobes;
        win_wr(8'h34, 8'hA5);
        cmp("R3", "write addr", last_addr, 16'h1234);
        win_rd(8'h34);
        cmp("R2", "read addr", last_addr, 16'h1234);
        cmp("R2", "read data", last_dout, 8'hA5);
        cmp("R2", "strobe count", strobes - s0, 2);

        pg_wr(8'h9C);
        cmp("R9", "reserved high page", pg_reserved, 0);
        win_rd(8'h34);
        cmp("R10", "new page used", last_addr, 16'h9C34);
        cmp("R10", "doe released", cpu_doe, 0);

        // R7: long phase, one access only
        s0 = strobes;
        bus_op(16'hFD40, 1'b1, 8'h00, 1'b1, 1'b0, 30, 30, 6);
        cmp("R7", "strobes in long phase", strobes - s0, 1);

        // R6: glitch shorter than the filter, then just long enough
        s0 = strobes;
        bus_op(16'hFD41, 1'b0, 8'h77, 1'b1, 1'b0, 8, F, 6);
        cmp("R6", "short pulse strobes", strobes - s0, 0);
        bus_op(16'hFD41, 1'b0, 8'h77, 1'b1, 1'b0, 8, F + 1, 6);
        cmp("R6", "min pulse strobes", strobes - s0, 1);

        // R5: selects with bus phase low
        s0 = strobes;
        @(posedge clk); #1;
        cpu_addr = 16'hFD50; cpu_rnw = 1'b0; cpu_wdata = 8'h11;
        win_sel_raw = 1'b1; preg_sel_raw = 1'b0; bus_phase = 1'b0;
        repeat (10) @(posedge clk);
        #1; win_sel_raw = 1'b0;
        @(posedge clk); #1; cpu_addr = 16'hFCFF; preg_sel_raw = 1'b1;
        repeat (10) @(posedge clk);
        #1; preg_sel_raw = 1'b0;
        repeat (3) @(posedge clk);
        cmp("R5", "strobes with phase low", strobes - s0, 0);
        cmp("R5", "page kept", pg_reserved, 0);

        // R8: qualified selects at other addresses
        s0 = strobes; d0 = doe_rises;
        bus_op(16'hFE10, 1'b1, 8'h00, 1'b1, 1'b0, 8, 8, 6);
        bus_op(16'hFCFE, 1'b0, 8'h55, 1'b0, 1'b1, 8, 8, 6);
        bus_op(16'hFCFE, 1'b1, 8'h00, 1'b0, 1'b1, 8, 8, 6);
        cmp("R8", "strobes elsewhere", strobes - s0, 0);
        cmp("R8", "doe elsewhere", doe_rises - d0, 0);
        pg_rd();
        cmp("R8", "page unchanged", last_dout, 8'h9C);

        // several pages and offsets
        for (int i = 0; i < 6; i++) begin
            pg_wr(8'(i * 37 + 5));
            win_wr(8'(i * 13), 8'(i * 7 + 1));
        end
        for (int i = 0; i < 6; i++) begin
            pg_wr(8'(i * 37 + 5));
            win_rd(8'(i * 13));
            cmp("R2", "multi-page data", last_dout, 8'(i * 7 + 1));
        end

        repeat (4) @(posedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule